// File: doc/BRIEF.md
# Doorbell Signal Interrupt Controller

This block lets processors ring numbered doorbells at one another. A doorbell is named by one 32-bit identifier word: the upper half selects a client and the lower half selects a signal within that client. Software rings a doorbell by writing the identifier word to a send register. The word is then presented on an outbound send port for a fabric to deliver. With loopback enabled, an in-range word also raises the matching local receive signal.

On the receive side, every client/signal pair has a pending flag and an enable flag. Pending flags are set by the inbound raise port or by loopback. One active-high level interrupt is high while any signal is both pending and enabled. The service routine reads a receive register to get the identifier of the highest-priority visible signal. It acknowledges that signal by writing the same word to a clear register. Enabling and disabling are done the same way, by writing the identifier word to separate registers. Another register drops every pending flag of one client at once.

The default size is four clients by sixteen signals. Both counts are parameters.

Top module: `ipc_doorbell`

## Requirements
- R1: After reset all pending and enable flags are zero: `irq` is 0, `send_valid` is 0, `rdata` is 0, and a read of the receive register returns 0xFFFFFFFF.
- R2: A write to offset 0x0C makes `send_valid` high for exactly the next cycle, with `send_id` equal to the written word, whatever the word's value.
- R3: An identifier word uses bits 31:16 for the client and bits 15:0 for the signal. An in-range word on the raise port (`raise_valid` high) sets that signal's pending flag. With LOOPBACK=1, an in-range word written to 0x0C does the same.
- R4: Writing an identifier word to 0x14 enables that signal, and writing it to 0x18 disables it. A disabled signal keeps its pending flag but is hidden from `irq` and from the receive register. Enabling it again makes it visible again.
- R5: A read (`rd_en` high) of offset 0x10 loads `rdata` at the next clock edge. The value is the identifier word of the pending, enabled signal with the lowest client, and within that client the lowest signal, or 0xFFFFFFFF if there is none. `rdata` holds its value while `rd_en` is low. A read of any other offset returns 0.
- R6: Writing an identifier word to 0x1C clears only that signal's pending flag.
- R7: Writing to 0x38 clears the pending flags of every signal of the client given in bits 31:16. Other clients are not affected.
- R8: `irq` is high exactly when some signal is both pending and enabled. It follows a state change at the clock edge that makes the change.
- R9: Identifier words whose client is at or above NUM_CLIENTS, or whose signal is at or above NUM_SIGS, have no effect on enable, disable, clear, client clear, raise or loopback. They do not alias onto in-range signals.
- R10: When a raise and a clear of the same signal arrive in the same cycle, the signal stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register byte offset |
| wdata | input | 32 | Write data (identifier word) |
| rdata | output | 32 | Read data, valid the cycle after `rd_en` |
| raise_valid | input | 1 | Inbound doorbell strobe |
| raise_id | input | 32 | Inbound doorbell identifier word |
| send_valid | output | 1 | Outbound doorbell strobe |
| send_id | output | 32 | Outbound doorbell identifier word |
| irq | output | 1 | Level summary interrupt, active high |

## Verification
A corrupted pending or enable flag shows up at `irq` in the cycle after the faulty edge. It also shows up at the next read of the receive register, which then returns a wrong identifier or a wrong sentinel. Priority faults are exposed by reading several signals that are pending at once and clearing them one by one, so that every read names the next expected winner. Aliasing faults are caught by writing out-of-range words whose truncated index lands on a live signal, then checking that this signal is still visible.

// File: rtl/ipc_doorbell_pkg.sv
package ipc_doorbell_pkg;

    localparam logic [7:0] OFS_SEND  = 8'h0C;
    localparam logic [7:0] OFS_RECV  = 8'h10;
    localparam logic [7:0] OFS_EN    = 8'h14;
    localparam logic [7:0] OFS_DIS   = 8'h18;
    localparam logic [7:0] OFS_CLR   = 8'h1C;
    localparam logic [7:0] OFS_CCLR  = 8'h38;

    localparam logic [31:0] NONE_PENDING = 32'hFFFF_FFFF;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_SEND,
        OP_EN,
        OP_DIS,
        OP_CLR,
        OP_CCLR
    } op_e;

    typedef struct packed {
        logic [15:0] client;
        logic [15:0] sig;
    } id_t;

    function automatic int width_of(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/ipc_db_idmap.sv
module ipc_db_idmap
    import ipc_doorbell_pkg::*;
#(
    parameter int NUM_CLIENTS = 4,
    parameter int NUM_SIGS    = 16,
    parameter int IDX_W       = 6,
    parameter int CL_W        = 2
) (
    input  id_t              id,
    output logic             sig_ok,
    output logic             cl_ok,
    output logic [IDX_W-1:0] idx,
    output logic [CL_W-1:0]  cl
);
    localparam logic [31:0] NS32 = 32'(NUM_SIGS);
    localparam logic [15:0] NC16 = 16'(NUM_CLIENTS);
    localparam logic [15:0] NS16 = 16'(NUM_SIGS);

    logic [31:0] flat;

    always_comb begin
        cl_ok  = (id.client < NC16);
        sig_ok = cl_ok && (id.sig < NS16);
        flat   = ({16'd0, id.client} * NS32) + {16'd0, id.sig};
        idx    = flat[IDX_W-1:0];
        cl     = id.client[CL_W-1:0];
    end
endmodule

// File: rtl/ipc_db_regdec.sv
module ipc_db_regdec
    import ipc_doorbell_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    output op_e               op
);
    always_comb begin
        op = OP_NONE;
        if (wr_en) begin
            unique case (addr)
                ADDR_W'(OFS_SEND): op = OP_SEND;
                ADDR_W'(OFS_EN):   op = OP_EN;
                ADDR_W'(OFS_DIS):  op = OP_DIS;
                ADDR_W'(OFS_CLR):  op = OP_CLR;
                ADDR_W'(OFS_CCLR): op = OP_CCLR;
                default:           op = OP_NONE;
            endcase
        end
    end
endmodule

// File: rtl/ipc_db_sigbank.sv
module ipc_db_sigbank
    import ipc_doorbell_pkg::*;
#(
    parameter int NUM_CLIENTS = 4,
    parameter int NUM_SIGS    = 16,
    parameter int TOTAL       = 64,
    parameter int IDX_W       = 6,
    parameter int CL_W        = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  op_e              cmd,
    input  logic             cmd_ok,
    input  logic             cmd_cl_ok,
    input  logic [IDX_W-1:0] cmd_idx,
    input  logic [CL_W-1:0]  cmd_cl,
    input  logic             ra_v,
    input  logic [IDX_W-1:0] ra_idx,
    input  logic             rb_v,
    input  logic [IDX_W-1:0] rb_idx,
    output logic [TOTAL-1:0] pend,
    output logic [TOTAL-1:0] en
);
    for (genvar i = 0; i < TOTAL; i++) begin : g_sig
        localparam int OWNER = i / NUM_SIGS;
        logic set_hit;
        logic sel;
        logic clr_hit;

        always_comb begin
            set_hit = (ra_v && (ra_idx == IDX_W'(i))) ||
                      (rb_v && (rb_idx == IDX_W'(i)));
            sel     = cmd_ok && (cmd_idx == IDX_W'(i));
            clr_hit = ((cmd == OP_CLR) && sel) ||
                      ((cmd == OP_CCLR) && cmd_cl_ok && (cmd_cl == CL_W'(OWNER)));
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                pend[i] <= 1'b0;
                en[i]   <= 1'b0;
            end else begin
                if (set_hit)
                    pend[i] <= 1'b1;
                else if (clr_hit)
                    pend[i] <= 1'b0;
                if ((cmd == OP_EN) && sel)
                    en[i] <= 1'b1;
                else if ((cmd == OP_DIS) && sel)
                    en[i] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/ipc_db_prio.sv
module ipc_db_prio #(
    parameter int TOTAL = 64,
    parameter int IDX_W = 6
) (
    input  logic [TOTAL-1:0] active,
    output logic             found,
    output logic [IDX_W-1:0] win
);
    always_comb begin
        found = 1'b0;
        win   = '0;
        for (int i = TOTAL - 1; i >= 0; i--) begin
            if (active[i]) begin
                found = 1'b1;
                win   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/ipc_doorbell.sv
module ipc_doorbell
    import ipc_doorbell_pkg::*;
#(
    parameter int NUM_CLIENTS = 4,
    parameter int NUM_SIGS    = 16,
    parameter int ADDR_W      = 8,
    parameter bit LOOPBACK    = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic              raise_valid,
    input  logic [31:0]       raise_id,
    output logic              send_valid,
    output logic [31:0]       send_id,
    output logic              irq
);
    localparam int TOTAL = NUM_CLIENTS * NUM_SIGS;
    localparam int IDX_W = width_of(TOTAL);
    localparam int CL_W  = width_of(NUM_CLIENTS);
    localparam logic [31:0] NS32 = 32'(NUM_SIGS);

    op_e              op;
    logic             w_ok, w_cl_ok, r_ok, r_cl_ok;
    logic [IDX_W-1:0] w_idx, r_idx, win_idx;
    logic [CL_W-1:0]  w_cl, r_cl;
    logic             lb_v;
    logic             win_found;
    logic [TOTAL-1:0] pend_vec, en_vec;
    id_t              win_id;

    ipc_db_regdec #(.ADDR_W(ADDR_W)) dec_i (
        .wr_en (wr_en),
        .addr  (addr),
        .op    (op)
    );

    ipc_db_idmap #(
        .NUM_CLIENTS(NUM_CLIENTS), .NUM_SIGS(NUM_SIGS), .IDX_W(IDX_W), .CL_W(CL_W)
    ) wmap_i (
        .id(id_t'(wdata)), .sig_ok(w_ok), .cl_ok(w_cl_ok), .idx(w_idx), .cl(w_cl)
    );

    ipc_db_idmap #(
        .NUM_CLIENTS(NUM_CLIENTS), .NUM_SIGS(NUM_SIGS), .IDX_W(IDX_W), .CL_W(CL_W)
    ) rmap_i (
        .id(id_t'(raise_id)), .sig_ok(r_ok), .cl_ok(r_cl_ok), .idx(r_idx), .cl(r_cl)
    );

    if (LOOPBACK) begin : g_lb
        assign lb_v = (op == OP_SEND) && w_ok;
    end else begin : g_nolb
        assign lb_v = 1'b0;
    end

    ipc_db_sigbank #(
        .NUM_CLIENTS(NUM_CLIENTS), .NUM_SIGS(NUM_SIGS), .TOTAL(TOTAL),
        .IDX_W(IDX_W), .CL_W(CL_W)
    ) bank_i (
        .clk       (clk),
        .rst       (rst),
        .cmd       (op),
        .cmd_ok    (w_ok),
        .cmd_cl_ok (w_cl_ok),
        .cmd_idx   (w_idx),
        .cmd_cl    (w_cl),
        .ra_v      (raise_valid && r_ok),
        .ra_idx    (r_idx),
        .rb_v      (lb_v),
        .rb_idx    (w_idx),
        .pend      (pend_vec),
        .en        (en_vec)
    );

    ipc_db_prio #(.TOTAL(TOTAL), .IDX_W(IDX_W)) prio_i (
        .active (pend_vec & en_vec),
        .found  (win_found),
        .win    (win_idx)
    );

    always_comb begin
        win_id.client = 16'(32'(win_idx) / NS32);
        win_id.sig    = 16'(32'(win_idx) % NS32);
    end

    assign irq = win_found;

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata      <= '0;
            send_valid <= 1'b0;
            send_id    <= '0;
        end else begin
            send_valid <= (op == OP_SEND);
            if (op == OP_SEND)
                send_id <= wdata;
            if (rd_en)
                rdata <= (addr == ADDR_W'(OFS_RECV)) ?
                         (win_found ? 32'(win_id) : NONE_PENDING) : 32'd0;
        end
    end
endmodule

// File: rtl/ipc_doorbell_chk.sv
module ipc_doorbell_chk
    import ipc_doorbell_pkg::*;
#(
    parameter int NUM_CLIENTS = 4,
    parameter int NUM_SIGS    = 16,
    parameter int ADDR_W      = 8,
    parameter int TOTAL       = 64
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [31:0]       wdata,
    input logic [31:0]       rdata,
    input logic              raise_valid,
    input logic [31:0]       raise_id,
    input logic              send_valid,
    input logic [31:0]       send_id,
    input logic              irq,
    input logic [TOTAL-1:0]  pend
);
    localparam logic [31:0] NS32 = 32'(NUM_SIGS);
    logic        wr_ok;
    logic [31:0] wr_flat;

    always_comb begin
        wr_ok   = (wdata[31:16] < 16'(NUM_CLIENTS)) && (wdata[15:0] < 16'(NUM_SIGS));
        wr_flat = ({16'd0, wdata[31:16]} * NS32) + {16'd0, wdata[15:0]};
    end

    // R2
    send_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == ADDR_W'(OFS_SEND)) |=> (send_valid && send_id == $past(wdata)));

    // R2
    send_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && addr == ADDR_W'(OFS_SEND)) |=> !send_valid);

    // R8
    irq_read_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == ADDR_W'(OFS_RECV) && irq) |=> (rdata != NONE_PENDING));

    // R5
    idle_read_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == ADDR_W'(OFS_RECV) && !irq) |=> (rdata == NONE_PENDING));

    // R5
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rdata));

    // R6
    clear_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == ADDR_W'(OFS_CLR) && wr_ok && !raise_valid)
        |=> !pend[$past(wr_flat)]);

    // R10
    raise_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == ADDR_W'(OFS_CLR) && wr_ok && raise_valid && raise_id == wdata)
        |=> pend[$past(wr_flat)]);
endmodule

bind ipc_doorbell ipc_doorbell_chk #(
    .NUM_CLIENTS(NUM_CLIENTS), .NUM_SIGS(NUM_SIGS), .ADDR_W(ADDR_W), .TOTAL(TOTAL)
) chk_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .raise_valid(raise_valid), .raise_id(raise_id),
    .send_valid(send_valid), .send_id(send_id), .irq(irq), .pend(pend_vec)
);

// File: tb/ipc_doorbell_tb.sv
module ipc_doorbell_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        raise_valid = 1'b0;
    logic [31:0] raise_id = '0;
    logic        send_valid;
    logic [31:0] send_id;
    logic        irq;

    int checks = 0;
    int bad = 0;

    localparam logic [31:0] NONE = 32'hFFFF_FFFF;

    always #10 clk = ~clk;

    ipc_doorbell dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .raise_valid(raise_valid), .raise_id(raise_id),
        .send_valid(send_valid), .send_id(send_id), .irq(irq)
    );

    function automatic logic [31:0] idw(input int c, input int s);
        return {16'(c), 16'(s)};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic raise(input logic [31:0] id);
        @(negedge clk);
        raise_valid = 1'b1; raise_id = id;
        @(negedge clk);
        raise_valid = 1'b0;
    endtask

    task automatic expect_recv(input string req, input logic [31:0] exp);
        logic [31:0] v;
        reg_rd(8'h10, v);
        check(req, v, exp);
    endtask

    task automatic t_reset();
        check("R1 irq", 32'(irq), 32'd0);
        check("R1 send_valid", 32'(send_valid), 32'd0);
        check("R1 rdata", rdata, 32'd0);
        expect_recv("R1 recv", NONE);
    endtask

    task automatic t_send();
        logic [31:0] v;
        reg_wr(8'h0C, 32'hABCD_0001);
        check("R2 send_valid", 32'(send_valid), 32'd1);
        check("R2 send_id", send_id, 32'hABCD_0001);
        @(negedge clk);
        check("R2 single pulse", 32'(send_valid), 32'd0);
        check("R9 no loopback", 32'(irq), 32'd0);
        reg_rd(8'h04, v);
        check("R5 other offset", v, 32'd0);
    endtask

    task automatic t_enable();
        raise(idw(2, 5));
        check("R4 disabled hidden irq", 32'(irq), 32'd0);
        expect_recv("R4 disabled hidden recv", NONE);
        reg_wr(8'h14, idw(2, 5));
        check("R8 irq on enable", 32'(irq), 32'd1);
        expect_recv("R3 R5 raised id", idw(2, 5));
        repeat (3) @(negedge clk);
        check("R5 rdata holds", rdata, idw(2, 5));
        reg_wr(8'h18, idw(2, 5));
        check("R4 irq off on disable", 32'(irq), 32'd0);
        expect_recv("R4 recv off on disable", NONE);
        reg_wr(8'h14, idw(2, 5));
        check("R4 visible again", 32'(irq), 32'd1);
    endtask

    task automatic t_priority();
        reg_wr(8'h0C, idw(1, 9));
        raise(idw(3, 0));
        reg_wr(8'h14, idw(1, 9));
        reg_wr(8'h14, idw(3, 0));
        reg_wr(8'h14, idw(1, 3));
        expect_recv("R3 R5 loopback lowest", idw(1, 9));
        raise(idw(1, 3));
        expect_recv("R5 lower signal first", idw(1, 3));
        reg_wr(8'h1C, idw(1, 3));
        expect_recv("R6 clear one", idw(1, 9));
        reg_wr(8'h1C, idw(1, 9));
        expect_recv("R6 next client", idw(2, 5));
        reg_wr(8'h1C, idw(2, 5));
        expect_recv("R6 last client", idw(3, 0));
    endtask

    task automatic t_client_clear();
        reg_wr(8'h14, idw(3, 7));
        raise(idw(3, 7));
        reg_wr(8'h14, idw(0, 1));
        raise(idw(0, 1));
        expect_recv("R5 client 0 first", idw(0, 1));
        reg_wr(8'h38, idw(3, 0));
        reg_wr(8'h1C, idw(0, 1));
        check("R7 client cleared irq", 32'(irq), 32'd0);
        expect_recv("R7 client cleared recv", NONE);
    endtask

    task automatic t_range();
        reg_wr(8'h14, idw(0, 2));
        raise(idw(0, 2));
        reg_wr(8'h1C, idw(4, 2));
        expect_recv("R9 clear out of range", idw(0, 2));
        reg_wr(8'h18, idw(4, 2));
        check("R9 disable out of range", 32'(irq), 32'd1);
        reg_wr(8'h38, idw(4, 0));
        expect_recv("R9 client clear out of range", idw(0, 2));
        reg_wr(8'h1C, idw(0, 2));
        raise(idw(4, 2));
        reg_wr(8'h0C, idw(0, 18));
        check("R9 raise out of range", 32'(irq), 32'd0);
    endtask

    task automatic t_collision();
        reg_wr(8'h14, idw(2, 8));
        @(negedge clk);
        wr_en = 1'b1; addr = 8'h1C; wdata = idw(2, 8);
        raise_valid = 1'b1; raise_id = idw(2, 8);
        @(negedge clk);
        wr_en = 1'b0; raise_valid = 1'b0;
        expect_recv("R10 raise beats clear", idw(2, 8));
        reg_wr(8'h1C, idw(2, 8));
        check("R6 R8 cleared after collision", 32'(irq), 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog R1-related actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_send();
        t_enable();
        t_priority();
        t_client_clear();
        t_range();
        t_collision();
        repeat (2) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule